// File: doc/BRIEF.md
# Critical-Conduction Boost Gate Timer

This block produces the gate drive bit for the boost switch of a power factor correction stage. The stage runs at the edge of continuous conduction, and the block handles one switching cycle at a time. A new cycle starts only when the demagnetisation comparator reports that the auxiliary winding has swung below zero. That is the valley of the drain ringing, so the switch closes near zero drain-source voltage. A higher-level control loop supplies the on-time as a word of clock ticks. The gate opens again when that time has run out, or earlier when the current-sense comparator trips.

Both comparator bits arrive asynchronously. Each passes through a two-flop synchroniser. A fixed blanking window follows every gate edge. After the gate falls, the window hides the ringing on the demagnetisation input. After the gate rises, it hides the turn-on spike on the current-sense input. A restart timer measures time off. If no valley arrives within a programmable time, the timer starts a cycle by itself, so the converter cannot stall. Two one-clock flags mark a cycle cut short by the current limit and a cycle launched by the restart timer.

Top module: `pfc_gate_timer`

## Requirements
- R1: During reset the gate and both flags are low. Whenever `en` is low, the gate is low in the same cycle and stays low. After `en` returns high, the block begins a fresh off period.
- R2: `zcd_raw` = 1 means the auxiliary winding is below zero. The gate rises only after an accepted valley (sampled through two flops) or a restart-timer expiry. The valley has priority when both occur together.
- R3: The demagnetisation input is ignored for the first `ZCB_TICKS` low clocks after every gate fall. With `zcd_raw` held at 1, the gate stays low for exactly `ZCB_TICKS`+1 clocks between pulses.
- R4: The on-time request is captured when the gate rises. Without a current-limit trip, the gate stays high for exactly that many clocks (1 gives a single-clock pulse).
- R5: `cs_raw` = 1 means over-threshold. It is ignored during the first `LEB_TICKS` high clocks. Once accepted, it drops the gate at the next edge, so the shortest limited pulse lasts `LEB_TICKS`+1 clocks. The gate then stays low until the next turn-on.
- R6: If no valley is accepted, the gate rises after `max(toff_max, ZCB_TICKS+1)` low clocks.
- R7: When a turn-on would happen while `ton_req` is 0, that cycle is skipped. The gate stays low, neither flag pulses, and a new off period starts.
- R8: `ocp_flag` is high for exactly the first low clock after a pulse ended by the current limit, and at no other time.
- R9: `restart_flag` is high for exactly the first high clock of a pulse started by the restart timer, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counts are in its ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Supervisor enable; low forces the gate off |
| zcd_raw | input | 1 | Asynchronous demagnetisation comparator, 1 = winding below zero |
| cs_raw | input | 1 | Asynchronous current-sense comparator, 1 = above limit |
| ton_req | input | W | Requested on-time in clocks, 0 = skip |
| toff_max | input | W | Restart-timer limit in clocks of off time |
| gate | output | 1 | Boost switch gate drive |
| ocp_flag | output | 1 | One-clock pulse after a current-limited pulse |
| restart_flag | output | 1 | One-clock pulse at a timer-started pulse |

## Verification
The assertions assume that `en` changes only between clock edges and never dips and recovers inside one clock period. Under that assumption, every gate rise is seen by the sampled state machine. They also assume that `ton_req` is steady around the edge at which the gate rises. The stimulus meets both conditions because it changes every input shortly after a rising edge. It only alters the on-time, off-time and comparator levels while `en` is low. The comparator inputs are held at fixed levels within each phase, so the synchronisers have settled before the gate is enabled.

// File: rtl/pfc_gate_timer.sv
module pfc_gate_timer #(
  parameter int W         = 12,
  parameter int LEB_TICKS = 8,
  parameter int ZCB_TICKS = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         zcd_raw,
  input  logic         cs_raw,
  input  logic [W-1:0] ton_req,
  input  logic [W-1:0] toff_max,
  output logic         gate,
  output logic         ocp_flag,
  output logic         restart_flag
);

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_OFF} st_t;

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] LEB_C   = W'(LEB_TICKS);
  localparam logic [W-1:0] ZCB_C   = W'(ZCB_TICKS);
  localparam logic [W-1:0] ONE     = W'(1);

  st_t          st;
  logic [1:0]   zcd_sy, cs_sy;
  logic [W-1:0] cnt, ton_q;

  logic zcd_s, cs_s;
  assign zcd_s = zcd_sy[1];
  assign cs_s  = cs_sy[1];

  wire [W-1:0] cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + ONE;

  // current limit only after leading-edge blanking
  wire cs_ok    = (st == ST_ON) && cs_s && (cnt > LEB_C);
  wire ton_done = (st == ST_ON) && (cnt >= ton_q);
  // demagnetisation input only after turn-off blanking
  wire zc_open  = (st == ST_OFF) && (cnt > ZCB_C);
  wire valley   = zc_open && zcd_s;
  wire timeout  = zc_open && !zcd_s && (cnt >= toff_max);
  wire fire     = valley || timeout;
  wire launch   = fire && (ton_req != '0);

  assign gate = (st == ST_ON) && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcd_sy <= '0;
      cs_sy  <= '0;
    end else begin
      zcd_sy <= {zcd_sy[0], zcd_raw};
      cs_sy  <= {cs_sy[0], cs_raw};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      ton_q        <= '0;
      ocp_flag     <= 1'b0;
      restart_flag <= 1'b0;
    end else begin
      ocp_flag     <= 1'b0;
      restart_flag <= 1'b0;
      if (!en) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            st  <= ST_OFF;
            cnt <= ONE;
          end
          ST_ON: begin
            if (cs_ok || ton_done) begin
              st       <= ST_OFF;
              cnt      <= ONE;
              ocp_flag <= cs_ok;
            end else begin
              cnt <= cnt_inc;
            end
          end
          ST_OFF: begin
            if (fire) begin
              cnt <= ONE;
              if (launch) begin
                st           <= ST_ON;
                ton_q        <= ton_req;
                restart_flag <= timeout;
              end
            end else begin
              cnt <= cnt_inc;
            end
          end
          default: begin
            st  <= ST_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pfc_gate_timer_chk.sv
module pfc_gate_timer_chk #(
  parameter int W         = 12,
  parameter int LEB_TICKS = 8,
  parameter int ZCB_TICKS = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         gate,
  input logic         ocp_flag,
  input logic         restart_flag,
  input logic [W-1:0] ton_req,
  input logic         zcd_s
);

  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= gate ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
      lo_cnt <= gate ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
    end
  end

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !gate);

  p_no_flags_after_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!ocp_flag && !restart_flag));

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(zcd_s) || restart_flag));

  p_off_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (lo_cnt >= 16'(ZCB_TICKS + 1)));

  p_leb_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag |-> (hi_cnt >= 16'(LEB_TICKS + 1)));

  p_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(ton_req) != '0));

  p_ocp_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_flag |-> (!gate && $past(gate)));

  p_restart_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_flag |-> (gate && !$past(gate)));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ocp_flag, restart_flag}));

endmodule

bind pfc_gate_timer pfc_gate_timer_chk #(
  .W(W), .LEB_TICKS(LEB_TICKS), .ZCB_TICKS(ZCB_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate(gate), .ocp_flag(ocp_flag),
  .restart_flag(restart_flag), .ton_req(ton_req), .zcd_s(zcd_s)
);

// File: tb/test_pfc_gate_timer.sv
module test_pfc_gate_timer;
  localparam int W   = 10;
  localparam int LEB = 4;
  localparam int ZCB = 6;

  typedef struct {
    int    hi;
    int    lo;
    bit    lo_chk;
    bit    ocp;
    bit    rst;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic zcd_raw = 1'b0;
  logic cs_raw = 1'b0;
  logic [W-1:0] ton_req = '0;
  logic [W-1:0] toff_max = '0;
  logic gate, ocp_flag, restart_flag;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  pfc_gate_timer #(.W(W), .LEB_TICKS(LEB), .ZCB_TICKS(ZCB)) i_pfc_gate_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd_raw(zcd_raw), .cs_raw(cs_raw),
    .ton_req(ton_req), .toff_max(toff_max), .gate(gate), .ocp_flag(ocp_flag),
    .restart_flag(restart_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor
  int  hi_run = 0, lo_run = 0, lo_at_rise = 0;
  bit  rst_seen = 0;
  logic g_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!en) begin
        hi_run = 0; lo_run = 0; g_prev = 1'b0;
      end else begin
        if (gate && !g_prev) begin
          rst_seen = restart_flag; lo_at_rise = lo_run; hi_run = 1;
        end else if (gate) begin
          hi_run++;
        end else if (g_prev) begin
          if (sb.size() == 0) begin
            check(1'b0, "R4 unexpected pulse", hi_run, 0);
          end else begin
            item_t it;
            it = sb.pop_front();
            check(hi_run == it.hi, {it.req, " high length"}, hi_run, it.hi);
            check(ocp_flag == it.ocp, "R8 ocp_flag at fall", ocp_flag, it.ocp);
            check(rst_seen == it.rst, "R9 restart_flag at rise", rst_seen, it.rst);
            if (it.lo_chk)
              check(lo_at_rise == it.lo, {it.req, " low length"}, lo_at_rise, it.lo);
          end
          lo_run = 1;
        end else begin
          lo_run++;
        end
        if (restart_flag && !(gate && !g_prev)) check(1'b0, "R9 stray restart_flag", 1, 0);
        if (ocp_flag && !(!gate && g_prev)) check(1'b0, "R8 stray ocp_flag", 1, 0);
        g_prev = gate;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic run_phase(input int t_on, input int t_off, input bit z, input bit c,
                           input int n, input int ehi, input int elo, input bit eocp,
                           input bit erst, input string rq);
    @(posedge clk); #2;
    ton_req = W'(t_on); toff_max = W'(t_off); zcd_raw = z; cs_raw = c;
    repeat (4) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.hi = ehi; it.lo = elo; it.lo_chk = (i != 0); it.ocp = eocp; it.rst = erst; it.req = rq;
      sb.push_back(it);
    end
    #2 en = 1'b1;
    do @(posedge clk); while (sb.size() != 0);
    #2 en = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!gate && !ocp_flag && !restart_flag, "R1 reset outputs", {gate, ocp_flag, restart_flag}, 0);
    @(posedge clk); #2 rst_n = 1'b1;

    // R1: disabled with a valley present
    zcd_raw = 1'b1; ton_req = W'(20); toff_max = W'(100);
    bad = 0;
    repeat (40) begin @(negedge clk); if (gate || ocp_flag || restart_flag) bad = 1; end
    check(!bad, "R1 gate held low while disabled", bad, 0);

    // R2 R3 R4: valley turn-on, blanking sets minimum off-time
    run_phase(20, 200, 1'b1, 1'b0, 4, 20, ZCB + 1, 1'b0, 1'b0, "R3 R4 valley");
    // R4: single-clock pulse
    run_phase(1, 200, 1'b1, 1'b0, 3, 1, ZCB + 1, 1'b0, 1'b0, "R4 one-tick");
    // R6 R9: restart timer with no valley
    run_phase(10, 30, 1'b0, 1'b0, 3, 10, 30, 1'b0, 1'b1, "R6 restart");
    // R6 R3: blanking longer than the restart limit
    run_phase(8, 2, 1'b0, 1'b0, 3, 8, ZCB + 1, 1'b0, 1'b1, "R6 short limit");
    // R5 R8: current limit after leading-edge blanking
    run_phase(40, 200, 1'b1, 1'b1, 3, LEB + 1, ZCB + 1, 1'b1, 1'b0, "R5 current limit");

    // R7: zero on-time skips
    @(posedge clk); #2 ton_req = '0; zcd_raw = 1'b1; cs_raw = 1'b0; toff_max = W'(20);
    repeat (4) @(posedge clk);
    #2 en = 1'b1;
    bad = 0;
    repeat (80) begin @(negedge clk); if (gate || ocp_flag || restart_flag) bad = 1; end
    check(!bad, "R7 zero on-time keeps gate low", bad, 0);
    @(posedge clk); #2 en = 1'b0;
    repeat (3) @(posedge clk);

    // R1: disable mid-pulse drops gate at once
    @(posedge clk); #2 ton_req = W'(50); zcd_raw = 1'b1;
    #2 en = 1'b1;
    do @(negedge clk); while (!gate);
    check(gate == 1'b1, "R2 valley pulse started", gate, 1);
    repeat (3) @(posedge clk);
    #2 en = 1'b0;
    #1 check(gate == 1'b0, "R1 gate off same cycle as disable", gate, 0);
    bad = 0;
    repeat (20) begin @(negedge clk); if (gate) bad = 1; end
    check(!bad, "R1 gate stays off", bad, 0);

    check(sb.size() == 0, "R4 all expected pulses seen", sb.size(), 0);
    finish_run();
  end
endmodule